// File: doc/BRIEF.md
# ADC Code Transition Calibration Monitor

This block watches the output codes of a data converter while a constant analog level is applied to its input. Trimming a converter means setting that level so the output sits exactly on the edge between two adjacent codes. Noise makes any single sample unreliable, so the block collects a window of conversions and decides from their statistics. It counts how many samples in the window land on or above the upper code of the target pair. It then reports whether the stream sits below the transition, above it, or is split evenly across it within a tolerance.

The block also runs the trimming procedure. It waits for a warm-up to finish, runs the offset step, and moves on to the gain step only after the offset step has settled. Settled means two windows in a row judged "on transition". The gain step ends the same way, and the block then holds a finished state. An out-of-range flag marks any window that contained a sample far from the target pair. A synchronous clear starts the current window again without changing the step.

Top module: `cal_transition_monitor`

## Requirements
- R1: After reset `phase` is 0 (idle), `verdict_vld` is 0, `verdict` is 0 and `done` is 0.
- R2: From idle, `start` moves `phase` to 1 (warm-up) on the next edge. The phase stays 1 until `warm_done` is high, then becomes 2 (offset). Codes presented in phases 0 and 1 produce no verdict.
- R3: A window holds N = 2^L accepted samples. L is `win_log` limited to the range 4..12 (values below 4 act as 4, above 12 as 12). `verdict_vld` pulses for one cycle on the clock edge after the edge that accepts the Nth sample.
- R4: Let H be the number of samples in the window at or above the upper code. The verdict is 3 (on transition) when N/2 - `tol` <= H <= N/2 + `tol`. Otherwise it is 1 (low) when H < N/2 and 2 (high) when H > N/2. `verdict` holds its value between pulses.
- R5: In phase 2 the target pair is lower code 0x2000 and upper code 0x2001. In phase 3 it is lower 0x0000 and upper 0x0001. A sample counts as high when its code is greater than or equal to the upper code.
- R6: A sample is far when it lies more than `far_dist` codes above the upper code or more than `far_dist` codes below the lower code. A far sample still counts toward its own side. `out_of_range` is updated with each verdict and is 1 exactly when the window held a far sample.
- R7: Two consecutive on-transition verdicts move `phase` from 2 to 3 (gain), or from 3 to 4 (finished). The phase changes on the same edge as the second verdict. Any other verdict resets the run of consecutive on-transition verdicts. Phase 3 is never entered except from phase 2.
- R8: `clr` discards the partial window and the run of consecutive on-transition verdicts and does not change `phase`. After `clr`, a verdict comes only after a further N samples.
- R9: `done` is 1 exactly in phase 4, and phase 4 is kept until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| clr | input | 1 | Restart the current window |
| start | input | 1 | Begin the procedure from idle |
| warm_done | input | 1 | Warm-up period has elapsed |
| code_vld | input | 1 | A conversion result is present |
| code | input | CW | Converter output code |
| win_log | input | 4 | Log2 of the window length |
| tol | input | TW | Allowed deviation of H from N/2 |
| far_dist | input | CW | Distance beyond which a sample is far |
| phase | output | 3 | 0 idle, 1 warm-up, 2 offset, 3 gain, 4 finished |
| verdict_vld | output | 1 | One-cycle pulse when a window completes |
| verdict | output | 2 | 0 none, 1 low, 2 high, 3 on transition |
| out_of_range | output | 1 | The last window held a far sample |
| done | output | 1 | Procedure finished |

## Verification
The assertions assume that `win_log`, `tol` and `far_dist` hold steady for the whole of a window. They also assume that `clr` is never asserted together with the sample that would close a window. The stimulus changes these settings only between windows. It drives `clr` only in the middle of a partial window. All inputs change on the falling clock edge, so every sample is seen once at the rising edge.

// File: rtl/cal_transition_monitor.sv
module cal_transition_monitor #(
  parameter int CW     = 14,
  parameter int LOGMIN = 4,
  parameter int LOGMAX = 12,
  parameter int TW     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic          warm_done,
  input  logic          code_vld,
  input  logic [CW-1:0] code,
  input  logic [3:0]    win_log,
  input  logic [TW-1:0] tol,
  input  logic [CW-1:0] far_dist,
  output logic [2:0]    phase,
  output logic          verdict_vld,
  output logic [1:0]    verdict,
  output logic          out_of_range,
  output logic          done
);
  localparam int CNTW = LOGMAX + 1;
  localparam int XW   = ((CNTW > TW) ? CNTW : TW) + 2;
  localparam int DW   = CW + 2;
  localparam logic [CW-1:0] OFS_CODE  = CW'(1) << (CW - 1);
  localparam logic [CW-1:0] GAIN_CODE = '0;
  localparam logic [2:0] P_IDLE = 3'd0, P_WARM = 3'd1, P_OFS = 3'd2,
                         P_GAIN = 3'd3, P_DONE = 3'd4;
  localparam logic [1:0] V_LOW = 2'd1, V_HIGH = 2'd2, V_ON = 2'd3;

  logic [CNTW-1:0] cnt, hicnt, n_len, new_hi;
  logic [3:0]      wl;
  logic [CW-1:0]   base;
  logic [DW-1:0]   code_x, lo_x, up_x, far_x;
  logic [XW-1:0]   hi_x, half_x, tol_x;
  logic            acc, is_up, is_far, last, on_tr, oor_acc, streak;
  logic [1:0]      cls;

  assign wl     = (win_log < 4'(LOGMIN)) ? 4'(LOGMIN) :
                  (win_log > 4'(LOGMAX)) ? 4'(LOGMAX) : win_log;
  assign n_len  = CNTW'(1) << wl;
  assign base   = (phase == P_GAIN) ? GAIN_CODE : OFS_CODE;
  assign code_x = DW'(code);
  assign lo_x   = DW'(base);
  assign up_x   = lo_x + DW'(1);
  assign far_x  = DW'(far_dist);
  assign is_up  = code_x >= up_x;
  assign is_far = (code_x > up_x + far_x) || (code_x + far_x < lo_x);
  assign acc    = (phase == P_OFS) || (phase == P_GAIN);
  assign last   = acc && code_vld && (cnt >= n_len - CNTW'(1));
  assign new_hi = hicnt + CNTW'(is_up);
  assign hi_x   = XW'(new_hi);
  assign half_x = XW'(n_len >> 1);
  assign tol_x  = XW'(tol);
  assign on_tr  = (hi_x + tol_x >= half_x) && (hi_x <= half_x + tol_x);
  assign cls    = on_tr ? V_ON : ((hi_x < half_x) ? V_LOW : V_HIGH);
  assign done   = (phase == P_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      cnt <= '0;
      hicnt <= '0;
      oor_acc <= 1'b0;
      streak <= 1'b0;
      verdict_vld <= 1'b0;
      verdict <= 2'd0;
      out_of_range <= 1'b0;
    end else begin
      verdict_vld <= 1'b0;
      case (phase)
        P_IDLE: if (start) phase <= P_WARM;
        P_WARM: if (warm_done) phase <= P_OFS;
        default: ;
      endcase
      if (clr) begin
        cnt <= '0;
        hicnt <= '0;
        oor_acc <= 1'b0;
        streak <= 1'b0;
      end else if (acc && code_vld) begin
        if (last) begin
          cnt <= '0;
          hicnt <= '0;
          oor_acc <= 1'b0;
          verdict <= cls;
          verdict_vld <= 1'b1;
          out_of_range <= oor_acc | is_far;
          if (cls == V_ON && streak) begin
            streak <= 1'b0;
            phase <= (phase == P_OFS) ? P_GAIN : P_DONE;
          end else begin
            streak <= (cls == V_ON);
          end
        end else begin
          cnt <= cnt + CNTW'(1);
          hicnt <= new_hi;
          oor_acc <= oor_acc | is_far;
        end
      end
    end
  end
endmodule

// File: rtl/cal_transition_monitor_chk.sv
module cal_transition_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       warm_done,
  input logic [2:0] phase,
  input logic       verdict_vld,
  input logic [1:0] verdict,
  input logic       done
);
  a_r2_warm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && !warm_done) |=> (phase == 3'd1));
  a_r2_verdict_phase: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> ($past(phase) == 3'd2 || $past(phase) == 3'd3));
  a_r4_verdict_code: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> (verdict != 2'd0));
  a_r7_gain_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3) |-> ($past(phase) == 3'd2 || $past(phase) == 3'd3));
  a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd4);
  a_r8_clr_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !verdict_vld);
  a_r8_clr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && phase == 3'd2) |=> (phase == 3'd2));
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

bind cal_transition_monitor cal_transition_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .warm_done(warm_done),
  .phase(phase), .verdict_vld(verdict_vld), .verdict(verdict), .done(done)
);

// File: tb/cal_transition_monitor_test.sv
module cal_transition_monitor_test;
  logic        clk = 1'b0, rst_n = 1'b0, clr = 1'b0, start = 1'b0, warm_done = 1'b0;
  logic        code_vld = 1'b0;
  logic [13:0] code = '0;
  logic [3:0]  win_log = 4'd4;
  logic [11:0] tol = 12'd1;
  logic [13:0] far_dist = 14'd100;
  logic [2:0]  phase;
  logic        verdict_vld, out_of_range, done;
  logic [1:0]  verdict;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cal_transition_monitor uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .warm_done(warm_done),
    .code_vld(code_vld), .code(code), .win_log(win_log), .tol(tol),
    .far_dist(far_dist), .phase(phase), .verdict_vld(verdict_vld),
    .verdict(verdict), .out_of_range(out_of_range), .done(done)
  );

  // {win_log, tol, high count, expected verdict}; total N = 2^clamp(win_log)
  localparam logic [30:0] TBL [0:7] = '{
    {4'd4, 12'd1, 13'd8,  2'd3},
    {4'd4, 12'd1, 13'd6,  2'd1},
    {4'd4, 12'd1, 13'd9,  2'd3},
    {4'd4, 12'd1, 13'd10, 2'd2},
    {4'd5, 12'd0, 13'd16, 2'd3},
    {4'd5, 12'd0, 13'd17, 2'd2},
    {4'd4, 12'd8, 13'd0,  2'd3},
    {4'd3, 12'd0, 13'd7,  2'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [13:0] c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      code_vld = 1'b1;
      code = c;
    end
  endtask

  task automatic idle_after;
    @(negedge clk);
    code_vld = 1'b0;
  endtask

  task automatic win(input logic [13:0] hc, input int nh, input logic [13:0] lc, input int nl);
    send(hc, nh);
    send(lc, nl);
    idle_after();
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(phase == 3'd0, "R1 phase", phase, 0);
    chk(!verdict_vld && verdict == 2'd0, "R1 verdict", verdict, 0);
    chk(!done, "R1 done", done, 0);
    rst_n = 1'b1;
    win(14'h2001, 8, 14'h2000, 8);
    chk(phase == 3'd0 && !verdict_vld, "R2 idle ignores codes", phase, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(phase == 3'd1, "R2 warmup", phase, 1);
    win(14'h2001, 8, 14'h2000, 8);
    chk(phase == 3'd1 && !verdict_vld, "R2 warmup hold", phase, 1);
    warm_done = 1'b1;
    @(negedge clk);
    chk(phase == 3'd2, "R2 offset entered", phase, 2);

    for (int k = 0; k < 8; k++) begin
      int wl, n, nh;
      win_log = TBL[k][30:27];
      tol = TBL[k][26:15];
      nh = int'(TBL[k][14:2]);
      wl = (win_log < 4) ? 4 : int'(win_log);
      n = 1 << wl;
      send(14'h2001, nh);
      send(14'h2000, n - nh - 1);
      chk(!verdict_vld, "R3 no early verdict", verdict_vld, 0);
      send(14'h2000, 1);
      idle_after();
      chk(verdict_vld, "R3 verdict pulse", verdict_vld, 1);
      chk(verdict == TBL[k][1:0], "R4 R5 verdict class", verdict, TBL[k][1:0]);
      chk(!out_of_range, "R6 near samples", out_of_range, 0);
      @(negedge clk);
      chk(!verdict_vld && verdict == TBL[k][1:0], "R4 verdict held", verdict, TBL[k][1:0]);
    end
    chk(phase == 3'd2, "R7 alternating stays offset", phase, 2);

    win_log = 4'd4; tol = 12'd1; far_dist = 14'd2;
    send(14'h2001, 10);
    @(negedge clk); code_vld = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(phase == 3'd2, "R8 clr keeps phase", phase, 2);
    send(14'h2000, 6);
    idle_after();
    chk(!verdict_vld, "R8 clr restarted window", verdict_vld, 0);
    win(14'h2001, 4, 14'h2000, 6);
    chk(verdict_vld && verdict == 2'd1, "R8 full window after clr", verdict, 1);

    win(14'h2004, 1, 14'h2000, 15);
    chk(verdict == 2'd1 && out_of_range, "R6 far above", out_of_range, 1);
    win(14'h2003, 16, 14'h2000, 0);
    chk(verdict == 2'd2 && !out_of_range, "R6 at far limit", out_of_range, 0);
    win(14'h2001, 8, 14'h1FFD, 8);
    chk(verdict == 2'd3 && out_of_range, "R6 far below counts low", verdict, 3);
    chk(phase == 3'd2, "R7 one on window", phase, 2);
    win(14'h2001, 8, 14'h2000, 8);
    chk(phase == 3'd3, "R7 offset to gain", phase, 3);
    chk(!out_of_range, "R6 flag cleared", out_of_range, 1'b0);

    win(14'h2000, 16, 14'h0000, 0);
    chk(verdict == 2'd2 && out_of_range, "R5 gain target", verdict, 2);
    win(14'h0001, 7, 14'h0000, 9);
    chk(verdict == 2'd3 && phase == 3'd3, "R5 gain pair on", verdict, 3);
    win(14'h0001, 9, 14'h0000, 7);
    chk(phase == 3'd4 && done, "R9 done", phase, 4);
    win(14'h0001, 8, 14'h0000, 8);
    chk(phase == 3'd4 && !verdict_vld, "R9 done kept", phase, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule